// File: doc/BRIEF.md
# Shadow Register Nonvolatile Commit Controller

This block holds a small bank of volatile configuration registers, each paired with a nonvolatile copy. It decides when a register's current value is copied into nonvolatile storage. Register zero is the configuration register. Its bit 3 is a write-control flag that selects one of two commit policies. When the flag is clear, every register write is followed by a copy of that register to storage. When the flag is set, ordinary writes stay volatile until an explicit commit command copies the whole bank. Writes to the configuration register are always copied at once, whatever the flag holds. Its low three bits give the low part of the device's bus slave address.

The nonvolatile store is modelled inside the block as a register array with a fixed write latency. It accepts one write at a time and reports busy while that write is in progress. Requests that arrive while a write is running are recorded as one dirty flag per register. A register written several times before its turn therefore costs a single storage write. After reset the block loads every volatile register from its nonvolatile copy and only then raises ready. A counter of storage writes lets an integrator see how much deferred commit saves in wear.

Top module: `shadow_commit_ctrl`

## Requirements
- R1: After reset deasserts, ready stays low and rises on the (NUM_REGS+2)th rising clock edge: two reset synchronizer stages, then one load cycle per register. Once ready is high, each volatile register equals its nonvolatile copy. The default image is 0x05, 0x3C, 0x81, 0xE7 for registers 0 to 3. Register writes and commit commands given while ready is low have no effect, and the write count stays 0.
- R2: The write-control flag is bit 3 of register 0 and is 0 in the default image. While it is 0, a write to any register updates that register's nonvolatile copy and adds one to the write count.
- R3: While the write-control flag is 1, a write to a register other than register 0 updates only the volatile copy. The nonvolatile copy and the write count do not change.
- R4: A write to register 0 always updates its nonvolatile copy and adds one to the write count, whatever the write-control flag holds.
- R5: A commit command copies every volatile register into nonvolatile storage and adds NUM_REGS to the write count.
- R6: A commit command that arrives while a storage write is in progress is kept. Once all writes finish, every nonvolatile copy equals its volatile register.
- R7: Each storage write holds busy high for exactly NV_LAT cycles. Only one write runs at a time, and the write count rises by one for each write started.
- R8: slave_addr_lo always shows bits 2 to 0 of volatile register 0.
- R9: Several writes to one register before its storage write starts merge into one storage write, which carries the most recent value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | $clog2(NUM_REGS) | Register index for the write |
| reg_wdata | input | DATA_W | Write data |
| commit_req | input | 1 | Commit-all command strobe |
| rd_idx | input | $clog2(NUM_REGS) | Index for both read outputs |
| rd_vol | output | DATA_W | Volatile value of register rd_idx |
| rd_nv | output | DATA_W | Nonvolatile value of register rd_idx |
| ready | output | 1 | Boot load finished |
| nv_busy | output | 1 | Storage write in progress |
| idle | output | 1 | Ready, not busy, nothing waiting to be written |
| nv_wr_count | output | CNT_W | Number of storage writes started |
| slave_addr_lo | output | 3 | Low bus slave address bits from register 0 |

## Verification
The assertions check the following on every cycle:
- no storage write starts during the boot load or while the store is busy;
- the busy countdown stays in range;
- each rise of busy is matched by a step of the write counter;
- a write to the configuration register, or any write with the flag clear, marks that register dirty in the next cycle;
- a commit command marks the whole bank dirty.

Only the bench scenarios can show the values that finally land in storage. They can also show the following:
- that deferred writes leave storage and the counter untouched;
- that a commit held over a busy write still copies the whole bank;
- that merged writes keep the newest data;
- how many cycles busy lasts.

// File: rtl/shadow_commit_pkg.sv
`timescale 1ns/1ps
package shadow_commit_pkg;
  localparam int unsigned DEF_NUM_REGS = 4;
  localparam int unsigned DEF_DATA_W   = 8;
  localparam int unsigned DEF_NV_LAT   = 4;
  localparam int unsigned DEF_CNT_W    = 16;
  // index of the configuration register (write-control flag, slave address)
  localparam int unsigned CFG_REG_IDX  = 0;
  localparam int unsigned WC_BIT       = 3;
  localparam int unsigned SLAVE_LO_W   = 3;
endpackage

// File: rtl/shadow_nv_array.sv
`timescale 1ns/1ps
module shadow_nv_array #(
  parameter int unsigned N   = 4,
  parameter int unsigned DW  = 8,
  parameter int unsigned LAT = 4,
  parameter logic [N*DW-1:0] INIT = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_start,
  input  logic [$clog2(N)-1:0]   wr_idx,
  input  logic [DW-1:0]          wr_data,
  output logic                   busy,
  output logic [N*DW-1:0]        image
);
  localparam int unsigned AW = $clog2(N);
  localparam int unsigned LW = $clog2(LAT + 1);

  logic          busy_q, busy_d;
  logic [LW-1:0] left_q, left_d;
  logic [AW-1:0] idx_q, idx_d;
  logic [DW-1:0] data_q, data_d;
  logic          done;
  logic [DW-1:0] mem_q [N];
  logic [DW-1:0] mem_d [N];

  always_comb begin
    busy_d = busy_q;
    left_d = left_q;
    idx_d  = idx_q;
    data_d = data_q;
    done   = 1'b0;
    if (busy_q) begin
      if (left_q == '0) begin
        busy_d = 1'b0;
        done   = 1'b1;
      end else begin
        left_d = left_q - 1'b1;
      end
    end else if (wr_start) begin
      busy_d = 1'b1;
      left_d = LW'(LAT - 1);
      idx_d  = wr_idx;
      data_d = wr_data;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      mem_d[i] = mem_q[i];
      if (done && idx_q == AW'(i)) mem_d[i] = data_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
      idx_q  <= '0;
      data_q <= '0;
      for (int i = 0; i < N; i++) mem_q[i] <= INIT[i*DW +: DW];
    end else begin
      busy_q <= busy_d;
      left_q <= left_d;
      idx_q  <= idx_d;
      data_q <= data_d;
      for (int i = 0; i < N; i++) mem_q[i] <= mem_d[i];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_img
    assign image[g*DW +: DW] = mem_q[g];
  end

  assign busy = busy_q;

  // R7: the scheduler never starts a write on a busy store
  a_r7_start_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> !busy_q);
  // R7: countdown never exceeds the programmed latency
  a_r7_countdown_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (left_q <= LW'(LAT - 1)));
endmodule

// File: rtl/shadow_commit_sched.sv
`timescale 1ns/1ps
module shadow_commit_sched #(
  parameter int unsigned N        = 4,
  parameter int unsigned ADDR_IDX = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 wr_en,
  input  logic [$clog2(N)-1:0] wr_idx,
  input  logic                 wc,
  input  logic                 commit,
  input  logic                 busy,
  output logic                 start,
  output logic [$clog2(N)-1:0] start_idx,
  output logic                 pending
);
  localparam int unsigned AW = $clog2(N);

  logic [N-1:0] dirty_q, dirty_d, set_v, clr_v;
  logic         found;

  // lowest-index dirty register goes first
  always_comb begin
    found     = 1'b0;
    start_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (dirty_q[i] && !found) begin
        found     = 1'b1;
        start_idx = AW'(i);
      end
    end
    start = found && !busy;
  end

  always_comb begin
    set_v = '0;
    if (en && commit) set_v = '1;
    if (en && wr_en && (wr_idx == AW'(ADDR_IDX) || !wc)) set_v[wr_idx] = 1'b1;
    clr_v = start ? (N'(1) << start_idx) : '0;
    // a new request in the same cycle as a start wins over the clear
    dirty_d = (dirty_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dirty_q <= '0;
    else        dirty_q <= dirty_d;
  end

  assign pending = |dirty_q;

  // R4: a configuration register write is always queued for storage
  a_r4_cfg_write_queued: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_en && wr_idx == AW'(ADDR_IDX)) |=> dirty_q[ADDR_IDX]);
  // R2: with the flag clear, any write is queued for storage
  a_r2_auto_queued: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_en && !wc) |=> dirty_q[$past(wr_idx)]);
  // R5: a commit command queues the whole bank
  a_r5_commit_queues_all: assert property (@(posedge clk) disable iff (!rst_n)
    (en && commit) |=> (&dirty_q));
endmodule

// File: rtl/shadow_commit_ctrl.sv
`timescale 1ns/1ps
module shadow_commit_ctrl
  import shadow_commit_pkg::*;
#(
  parameter int unsigned NUM_REGS = DEF_NUM_REGS,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned NV_LAT   = DEF_NV_LAT,
  parameter int unsigned CNT_W    = DEF_CNT_W,
  parameter logic [NUM_REGS*DATA_W-1:0] NV_INIT = 32'hE781_3C05
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [$clog2(NUM_REGS)-1:0] reg_idx,
  input  logic [DATA_W-1:0]           reg_wdata,
  input  logic                        commit_req,
  input  logic [$clog2(NUM_REGS)-1:0] rd_idx,
  output logic [DATA_W-1:0]           rd_vol,
  output logic [DATA_W-1:0]           rd_nv,
  output logic                        ready,
  output logic                        nv_busy,
  output logic                        idle,
  output logic [CNT_W-1:0]            nv_wr_count,
  output logic [SLAVE_LO_W-1:0]       slave_addr_lo
);
  localparam int unsigned AW = $clog2(NUM_REGS);

  logic                         rst_meta, rst_sync;
  logic                         ready_q, ready_d;
  logic [AW-1:0]                boot_q, boot_d;
  logic [DATA_W-1:0]            vreg_q [NUM_REGS];
  logic [DATA_W-1:0]            vreg_d [NUM_REGS];
  logic [NUM_REGS*DATA_W-1:0]   image;
  logic                         nv_start, pending;
  logic [AW-1:0]                start_idx;
  logic [CNT_W-1:0]             cnt_q, cnt_d;
  logic                         wc;
  logic                         wr_ok;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync, rst_meta} <= 2'b00;
    else        {rst_sync, rst_meta} <= {rst_meta, 1'b1};
  end

  assign wc    = vreg_q[CFG_REG_IDX][WC_BIT];
  assign wr_ok = ready_q && reg_wr;

  // boot loader and volatile bank, next state
  always_comb begin
    ready_d = ready_q | (boot_q == AW'(NUM_REGS - 1));
    boot_d  = ready_q ? boot_q : boot_q + 1'b1;
    cnt_d   = nv_start ? cnt_q + 1'b1 : cnt_q;
    for (int i = 0; i < NUM_REGS; i++) begin
      vreg_d[i] = vreg_q[i];
      if (!ready_q && boot_q == AW'(i))
        vreg_d[i] = image[i*DATA_W +: DATA_W];
      else if (wr_ok && reg_idx == AW'(i))
        vreg_d[i] = reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      ready_q <= 1'b0;
      boot_q  <= '0;
      cnt_q   <= '0;
      for (int i = 0; i < NUM_REGS; i++) vreg_q[i] <= '0;
    end else begin
      ready_q <= ready_d;
      boot_q  <= boot_d;
      cnt_q   <= cnt_d;
      for (int i = 0; i < NUM_REGS; i++) vreg_q[i] <= vreg_d[i];
    end
  end

  shadow_commit_sched #(
    .N        (NUM_REGS),
    .ADDR_IDX (CFG_REG_IDX)
  ) u_sched (
    .clk       (clk),
    .rst_n     (rst_sync),
    .en        (ready_q),
    .wr_en     (reg_wr),
    .wr_idx    (reg_idx),
    .wc        (wc),
    .commit    (commit_req),
    .busy      (nv_busy),
    .start     (nv_start),
    .start_idx (start_idx),
    .pending   (pending)
  );

  shadow_nv_array #(
    .N    (NUM_REGS),
    .DW   (DATA_W),
    .LAT  (NV_LAT),
    .INIT (NV_INIT)
  ) u_nv (
    .clk      (clk),
    .rst_n    (rst_sync),
    .wr_start (nv_start),
    .wr_idx   (start_idx),
    .wr_data  (vreg_q[start_idx]),
    .busy     (nv_busy),
    .image    (image)
  );

  assign rd_vol        = vreg_q[rd_idx];
  assign rd_nv         = image[int'(rd_idx)*DATA_W +: DATA_W];
  assign ready         = ready_q;
  assign idle          = ready_q && !nv_busy && !pending;
  assign nv_wr_count   = cnt_q;
  assign slave_addr_lo = vreg_q[CFG_REG_IDX][SLAVE_LO_W-1:0];

  // R1: storage is never written while the bank is still loading
  a_r1_quiet_during_boot: assert property (@(posedge clk) disable iff (!rst_sync)
    !ready_q |-> !nv_start);
  // R1: once ready, the block stays ready until the next reset
  a_r1_ready_sticky: assert property (@(posedge clk) disable iff (!rst_sync)
    ready_q |=> ready_q);
  // R7: every storage write that raises busy has been counted
  a_r7_busy_counted: assert property (@(posedge clk) disable iff (!rst_sync)
    $rose(nv_busy) |-> (cnt_q != $past(cnt_q)));
endmodule

// File: tb/shadow_commit_ctrl_tb.sv
`timescale 1ns/1ps
module shadow_commit_ctrl_tb;
  localparam int N   = 4;
  localparam int DW  = 8;
  localparam int LAT = 4;
  localparam int AW  = 2;
  localparam logic [N*DW-1:0] INIT = 32'hE781_3C05;

  logic          clk;
  logic          rst_n;
  logic          reg_wr;
  logic [AW-1:0] reg_idx;
  logic [DW-1:0] reg_wdata;
  logic          commit_req;
  logic [AW-1:0] rd_idx;
  logic [DW-1:0] rd_vol, rd_nv;
  logic          ready, nv_busy, idle;
  logic [15:0]   nv_wr_count;
  logic [2:0]    slave_addr_lo;

  int n_chk = 0;
  int n_err = 0;
  logic [DW-1:0] m_vol [N];
  logic [DW-1:0] m_nv  [N];
  int m_cnt;

  shadow_commit_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .commit_req(commit_req), .rd_idx(rd_idx),
    .rd_vol(rd_vol), .rd_nv(rd_nv), .ready(ready), .nv_busy(nv_busy),
    .idle(idle), .nv_wr_count(nv_wr_count), .slave_addr_lo(slave_addr_lo)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic wc_of(logic [DW-1:0] v);
    return v[3];
  endfunction

  task automatic check_all(string tag);
    for (int i = 0; i < N; i++) begin
      rd_idx = AW'(i);
      #1;
      chk({tag, " vol"}, 32'(rd_vol), 32'(m_vol[i]));
      chk({tag, " nv"},  32'(rd_nv),  32'(m_nv[i]));
    end
    chk({tag, " count"}, 32'(nv_wr_count), 32'(m_cnt));
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!idle) @(negedge clk);
  endtask

  // expected result of one register write, from R2, R3, R4
  task automatic model_write(int idx, logic [DW-1:0] d);
    logic w;
    w = wc_of(m_vol[0]);
    m_vol[idx] = d;
    if (idx == 0 || !w) begin
      m_nv[idx] = d;
      m_cnt++;
    end
  endtask

  task automatic model_commit();
    for (int i = 0; i < N; i++) m_nv[i] = m_vol[i];
    m_cnt += N;
  endtask

  task automatic do_write(int idx, logic [DW-1:0] d);
    model_write(idx, d);
    reg_wr = 1'b1; reg_idx = AW'(idx); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    wait_idle();
  endtask

  task automatic do_commit();
    model_commit();
    commit_req = 1'b1;
    @(negedge clk);
    commit_req = 1'b0;
    wait_idle();
  endtask

  initial begin
    int low_cnt;
    int bcnt;
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    rd_idx = '0;
    // R1: strobes held during reset and boot must be ignored
    reg_wr = 1'b1; reg_idx = '0; reg_wdata = 8'hFF; commit_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 32'(ready), 32'd0);
    chk("R1 count in reset", 32'(nv_wr_count), 32'd0);
    rst_n = 1'b1;
    low_cnt = 0;
    forever begin
      @(negedge clk);
      if (ready) break;
      low_cnt++;
      if (low_cnt == N) begin reg_wr = 1'b0; commit_req = 1'b0; end
      if (low_cnt > 40) break;
    end
    reg_wr = 1'b0; commit_req = 1'b0;
    chk("R1 boot cycles", 32'(low_cnt), 32'(N + 1));
    for (int i = 0; i < N; i++) begin
      m_vol[i] = INIT[i*DW +: DW];
      m_nv[i]  = INIT[i*DW +: DW];
    end
    m_cnt = 0;
    @(negedge clk);
    check_all("R1 boot image");
    chk("R8 default slave bits", 32'(slave_addr_lo), 32'd5);

    // R2: flag clear, auto commit
    do_write(2, 8'h5A);
    check_all("R2 auto commit");

    // R7: busy length
    model_write(1, 8'h77);
    reg_wr = 1'b1; reg_idx = 2'd1; reg_wdata = 8'h77;
    @(negedge clk);
    reg_wr = 1'b0;
    bcnt = 0;
    repeat (LAT + 6) begin
      @(negedge clk);
      if (nv_busy) bcnt++;
    end
    chk("R7 busy cycles", 32'(bcnt), 32'(LAT));
    check_all("R7 single write");

    // R4 / R8: set flag through register 0, committed anyway
    do_write(0, 8'h0B);
    check_all("R4 cfg write");
    chk("R8 slave bits", 32'(slave_addr_lo), 32'd3);

    // R3: deferred writes
    do_write(3, 8'h11);
    do_write(1, 8'hC4);
    check_all("R3 deferred");

    // R5: commit all
    do_commit();
    check_all("R5 commit");

    // R6: commit while busy
    do_write(2, 8'h99);
    model_write(0, 8'h0C);
    reg_wr = 1'b1; reg_idx = 2'd0; reg_wdata = 8'h0C;
    @(negedge clk);
    reg_wr = 1'b0;
    @(negedge clk);
    chk("R6 busy at commit", 32'(nv_busy), 32'd1);
    model_commit();
    commit_req = 1'b1;
    @(negedge clk);
    commit_req = 1'b0;
    wait_idle();
    check_all("R6 held commit");

    // R9: merged writes, flag cleared first
    do_write(0, 8'h04);
    model_write(0, 8'h06);
    reg_wr = 1'b1; reg_idx = 2'd0; reg_wdata = 8'h06;
    @(negedge clk);
    reg_idx = 2'd1; reg_wdata = 8'h33;
    @(negedge clk);
    reg_wdata = 8'h44;
    @(negedge clk);
    reg_wr = 1'b0;
    m_vol[1] = 8'h44; m_nv[1] = 8'h44; m_cnt++;
    wait_idle();
    check_all("R9 merged");

    // random mix covering R2 R3 R4 R5
    for (int k = 0; k < 60; k++) begin
      int op;
      int idx;
      logic [DW-1:0] d;
      op  = int'($urandom_range(0, 9));
      idx = int'($urandom_range(0, N - 1));
      d   = DW'($urandom);
      if (op == 0) do_commit();
      else         do_write(idx, d);
      check_all("R2 R3 R4 R5 random");
      chk("R8 random slave bits", 32'(slave_addr_lo), 32'(m_vol[0][2:0]));
    end

    summary();
    $finish;
  end
endmodule